// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is the execution half of a small processor. It holds a bank of general registers, two combinational read ports and one write port. A shared function unit combines an adder-based arithmetic section with a logic and shift section. A single packed control word, supplied every cycle by an external control unit, steers every part of the block. The control word picks the registers that drive the two operand buses. It picks whether the second operand comes from a register or from an external constant, and which function the unit computes. It also picks whether the write-back bus carries the function result or external data, and whether anything is written at all.

Bus A and bus B are brought out so that a surrounding system can use them as a memory address and memory write data. The four status flags go back to the control unit for branch decisions. Instruction fetch, decoding and memory lie outside this block.

Top module: `dp_datapath`

## Requirements
- R1: The control word is 16 bits wide with fields packed from the MSB down: destination select [15:13], A select [12:10], B select [9:7], constant enable [6], function select [5:2], external-data enable [1], write enable [0].
- R2: Reads are combinational. bus_a_o shows the register chosen by A select. bus_b_o shows the register chosen by B select when constant enable is 0, and const_in when it is 1.
- R3: With write enable 1, the write-back bus is stored on the rising clock edge into the register chosen by destination select. Before that edge, a read of the same register still returns the old value.
- R4: With write enable 0, no register changes, whatever the other fields and data_in hold.
- R5: The write-back bus carries the function-unit result when external-data enable is 0, and data_in when it is 1.
- R6: Function codes 0000 to 0111 compute A + Y + cin. Y is 0 for codes 000x, B for 001x, ~B for 010x and all ones for 011x, and cin is the code's LSB. This gives: transfer A, A+1, A+B, A+B+1, A+~B, A-B, A-1, transfer A. C is the carry out of bit 15. V is 1 when A and Y have equal sign bits and the result's sign bit differs.
- R7: Codes 1000, 1001, 1010 and 1011 give A AND B, A OR B, A XOR B and NOT A, with C and V both 0.
- R8: Codes 1100 and 1111 pass B, code 1101 shifts B right by one and code 1110 shifts B left by one, filling with zero. C and V are both 0.
- R9: Z is 1 exactly when the function-unit result is all zeros, and N equals its bit 15. Both follow the function unit even when external-data enable is 1.
- R10: A synchronous active-high reset clears all eight registers on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 16 | Packed control word |
| const_in | input | 16 | External constant for bus B |
| data_in | input | 16 | External data for the write-back bus |
| bus_a_o | output | 16 | Operand bus A (memory address) |
| bus_b_o | output | 16 | Operand bus B (memory write data) |
| flag_c | output | 1 | Carry |
| flag_v | output | 1 | Signed overflow |
| flag_z | output | 1 | Zero result |
| flag_n | output | 1 | Sign of result |

## Verification
The bench builds the block with its default sizes: a 16-bit word and eight registers, which makes the control word exactly 16 bits. At this width the bench can hand-pick operands on the signed and unsigned wrap boundaries (0x7FFF, 0x8000, 0xFFFF, 0x0000). These show the carry and overflow flags diverging. They also show the edge-dropped bit of each one-place shift. Every register address is reachable, so the reset clear is confirmed across the whole bank.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int FS_W = 4;

  // Function-select codes
  localparam logic [FS_W-1:0] FN_MOVA  = 4'b0000;
  localparam logic [FS_W-1:0] FN_INC   = 4'b0001;
  localparam logic [FS_W-1:0] FN_ADD   = 4'b0010;
  localparam logic [FS_W-1:0] FN_ADDC  = 4'b0011;
  localparam logic [FS_W-1:0] FN_ADDNB = 4'b0100;
  localparam logic [FS_W-1:0] FN_SUB   = 4'b0101;
  localparam logic [FS_W-1:0] FN_DEC   = 4'b0110;
  localparam logic [FS_W-1:0] FN_MOVA2 = 4'b0111;

  // Low three bits of a logic/shift code
  localparam logic [2:0] LS_AND = 3'b000;
  localparam logic [2:0] LS_OR  = 3'b001;
  localparam logic [2:0] LS_XOR = 3'b010;
  localparam logic [2:0] LS_NOT = 3'b011;
  localparam logic [2:0] LS_PB  = 3'b100;
  localparam logic [2:0] LS_SHR = 3'b101;
  localparam logic [2:0] LS_SHL = 3'b110;
  localparam logic [2:0] LS_PB2 = 3'b111;

  typedef enum logic [1:0] {
    Y_ZERO = 2'b00,
    Y_B    = 2'b01,
    Y_NB   = 2'b10,
    Y_ONES = 2'b11
  } y_src_e;
endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int W      = 16,
  parameter int NREG   = 8,
  parameter int ADDR_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [W-1:0]      wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [W-1:0]      rdata_a,
  output logic [W-1:0]      rdata_b
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst) begin
        regs[i] <= '0;
      end else if (we && (waddr == ADDR_W'(i))) begin
        regs[i] <= wdata;
      end
    end
  end

  always_comb begin
    rdata_a = regs[raddr_a];
    rdata_b = regs[raddr_b];
  end
endmodule

// File: rtl/dp_arith.sv
module dp_arith
  import dp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   sel,
  output logic [W-1:0] res,
  output logic         carry,
  output logic         ovf
);
  logic [W-1:0] y;
  logic [W:0]   sum;
  y_src_e       ysrc;

  always_comb begin
    ysrc = y_src_e'(sel[2:1]);
    unique case (ysrc)
      Y_ZERO:  y = '0;
      Y_B:     y = b;
      Y_NB:    y = ~b;
      default: y = '1;
    endcase
    sum   = {1'b0, a} + {1'b0, y} + {{W{1'b0}}, sel[0]};
    res   = sum[W-1:0];
    carry = sum[W];
    ovf   = (a[W-1] == y[W-1]) && (sum[W-1] != a[W-1]);
  end
endmodule

// File: rtl/dp_logic_shift.sv
module dp_logic_shift
  import dp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   sel,
  output logic [W-1:0] res
);
  always_comb begin
    unique case (sel)
      LS_AND:  res = a & b;
      LS_OR:   res = a | b;
      LS_XOR:  res = a ^ b;
      LS_NOT:  res = ~a;
      LS_SHR:  res = {1'b0, b[W-1:1]};
      LS_SHL:  res = {b[W-2:0], 1'b0};
      LS_PB, LS_PB2: res = b;
      default: res = b;
    endcase
  end
endmodule

// File: rtl/dp_datapath.sv
module dp_datapath
  import dp_pkg::*;
#(
  parameter int W      = 16,
  parameter int NREG   = 8,
  localparam int ADDR_W = $clog2(NREG),
  localparam int CW_W   = 3 * ADDR_W + FS_W + 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CW_W-1:0] ctrl_word,
  input  logic [W-1:0]    const_in,
  input  logic [W-1:0]    data_in,
  output logic [W-1:0]    bus_a_o,
  output logic [W-1:0]    bus_b_o,
  output logic            flag_c,
  output logic            flag_v,
  output logic            flag_z,
  output logic            flag_n
);
  // Field positions, MSB first
  localparam int RW_POS = 0;
  localparam int MD_POS = 1;
  localparam int FS_LO  = 2;
  localparam int MB_POS = FS_LO + FS_W;
  localparam int BA_LO  = MB_POS + 1;
  localparam int AA_LO  = BA_LO + ADDR_W;
  localparam int DA_LO  = AA_LO + ADDR_W;

  logic [ADDR_W-1:0] dst_sel, a_sel, b_sel;
  logic              b_from_const, d_from_ext, reg_we;
  logic [FS_W-1:0]   fsel;
  logic [W-1:0]      reg_a, reg_b, wb_bus, fu_res;
  logic [W-1:0]      ar_res, ls_res;
  logic              ar_c, ar_v;

  always_comb begin
    dst_sel      = ctrl_word[DA_LO +: ADDR_W];
    a_sel        = ctrl_word[AA_LO +: ADDR_W];
    b_sel        = ctrl_word[BA_LO +: ADDR_W];
    b_from_const = ctrl_word[MB_POS];
    fsel         = ctrl_word[FS_LO +: FS_W];
    d_from_ext   = ctrl_word[MD_POS];
    reg_we       = ctrl_word[RW_POS];
  end

  dp_regfile #(.W(W), .NREG(NREG), .ADDR_W(ADDR_W)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (reg_we),
    .waddr   (dst_sel),
    .wdata   (wb_bus),
    .raddr_a (a_sel),
    .raddr_b (b_sel),
    .rdata_a (reg_a),
    .rdata_b (reg_b)
  );

  always_comb begin
    bus_a_o = reg_a;
    bus_b_o = b_from_const ? const_in : reg_b;
  end

  dp_arith #(.W(W)) u_arith (
    .a     (bus_a_o),
    .b     (bus_b_o),
    .sel   (fsel[2:0]),
    .res   (ar_res),
    .carry (ar_c),
    .ovf   (ar_v)
  );

  dp_logic_shift #(.W(W)) u_ls (
    .a   (bus_a_o),
    .b   (bus_b_o),
    .sel (fsel[2:0]),
    .res (ls_res)
  );

  always_comb begin
    if (fsel[FS_W-1]) begin
      fu_res = ls_res;
      flag_c = 1'b0;
      flag_v = 1'b0;
    end else begin
      fu_res = ar_res;
      flag_c = ar_c;
      flag_v = ar_v;
    end
    flag_z = (fu_res == '0);
    flag_n = fu_res[W-1];
    wb_bus = d_from_ext ? data_in : fu_res;
  end
endmodule

// File: rtl/dp_checker.sv
module dp_checker #(
  parameter int W      = 16,
  parameter int ADDR_W = 3,
  parameter int FS_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] dst_sel,
  input logic [ADDR_W-1:0] a_sel,
  input logic [FS_W-1:0]   fsel,
  input logic              d_from_ext,
  input logic              reg_we,
  input logic [W-1:0]      wb_bus,
  input logic [W-1:0]      bus_a_o,
  input logic              flag_c,
  input logic              flag_v,
  input logic              flag_z,
  input logic              flag_n
);
  p_write_back_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(reg_we) && (a_sel == $past(dst_sel)))
      |-> (bus_a_o == $past(wb_bus)));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(reg_we) && (a_sel == $past(a_sel)))
      |-> (bus_a_o == $past(bus_a_o)));

  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bus_a_o == '0));

  // Covers R8 as well: logic and shift codes share the top select bit
  p_logic_flags_r7: assert property (@(posedge clk) disable iff (rst)
    fsel[FS_W-1] |-> (!flag_c && !flag_v));

  p_sign_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !d_from_ext |-> ((flag_n == wb_bus[W-1]) && (flag_z == (wb_bus == '0))));
endmodule

bind dp_datapath dp_checker #(.W(W), .ADDR_W(ADDR_W), .FS_W(dp_pkg::FS_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dst_sel    (dst_sel),
  .a_sel      (a_sel),
  .fsel       (fsel),
  .d_from_ext (d_from_ext),
  .reg_we     (reg_we),
  .wb_bus     (wb_bus),
  .bus_a_o    (bus_a_o),
  .flag_c     (flag_c),
  .flag_v     (flag_v),
  .flag_z     (flag_z),
  .flag_n     (flag_n)
);

// File: tb/tb_dp_datapath.sv
`timescale 1ns/1ps
module tb_dp_datapath;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ctrl_word = '0;
  logic [15:0] const_in = '0;
  logic [15:0] data_in = '0;
  logic [15:0] bus_a_o, bus_b_o;
  logic        flag_c, flag_v, flag_z, flag_n;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dp_datapath dut (
    .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .const_in(const_in),
    .data_in(data_in), .bus_a_o(bus_a_o), .bus_b_o(bus_b_o),
    .flag_c(flag_c), .flag_v(flag_v), .flag_z(flag_z), .flag_n(flag_n)
  );

  // {fs, a, b, result, c, v}
  localparam int NV = 23;
  localparam logic [53:0] VEC [NV] = '{
    {4'h2, 16'h1234, 16'h0F0F, 16'h2143, 1'b0, 1'b0},
    {4'h2, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 1'b0},
    {4'h2, 16'h7FFF, 16'h0001, 16'h8000, 1'b0, 1'b1},
    {4'h2, 16'h8000, 16'h8000, 16'h0000, 1'b1, 1'b1},
    {4'h5, 16'h0005, 16'h0003, 16'h0002, 1'b1, 1'b0},
    {4'h5, 16'h0003, 16'h0005, 16'hFFFE, 1'b0, 1'b0},
    {4'h5, 16'h8000, 16'h0001, 16'h7FFF, 1'b1, 1'b1},
    {4'h1, 16'hFFFF, 16'h0000, 16'h0000, 1'b1, 1'b0},
    {4'h6, 16'h0000, 16'h0000, 16'hFFFF, 1'b0, 1'b0},
    {4'h6, 16'h8000, 16'h0000, 16'h7FFF, 1'b1, 1'b1},
    {4'h0, 16'hABCD, 16'h1111, 16'hABCD, 1'b0, 1'b0},
    {4'h7, 16'hABCD, 16'h1111, 16'hABCD, 1'b1, 1'b0},
    {4'h3, 16'h0001, 16'h0002, 16'h0004, 1'b0, 1'b0},
    {4'h4, 16'h0005, 16'h0003, 16'h0001, 1'b1, 1'b0},
    {4'h8, 16'hF0F0, 16'hFF00, 16'hF000, 1'b0, 1'b0},
    {4'h9, 16'hF0F0, 16'h0F00, 16'hFFF0, 1'b0, 1'b0},
    {4'hA, 16'hAAAA, 16'hFFFF, 16'h5555, 1'b0, 1'b0},
    {4'hB, 16'h00FF, 16'h1234, 16'hFF00, 1'b0, 1'b0},
    {4'hC, 16'h0000, 16'h8001, 16'h8001, 1'b0, 1'b0},
    {4'hD, 16'hFFFF, 16'h8001, 16'h4000, 1'b0, 1'b0},
    {4'hE, 16'hFFFF, 16'h8001, 16'h0002, 1'b0, 1'b0},
    {4'hF, 16'h0000, 16'h1357, 16'h1357, 1'b0, 1'b0},
    {4'h8, 16'h1234, 16'h0000, 16'h0000, 1'b0, 1'b0}
  };

  function automatic logic [15:0] mk(input logic [2:0] da, input logic [2:0] aa,
                                     input logic [2:0] ba, input logic mb,
                                     input logic [3:0] fs, input logic md,
                                     input logic rw);
    return {da, aa, ba, mb, fs, md, rw};  // R1 field order
  endfunction

  task automatic step(input logic [15:0] cw, input logic [15:0] k, input logic [15:0] d);
    @(negedge clk);
    ctrl_word = cw;
    const_in  = k;
    data_in   = d;
    #1;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [3:0] fs;
    logic [15:0] r;
    string tag;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10: reset state of every register via both read ports
    for (int i = 0; i < 8; i++) begin
      step(mk(3'd0, 3'(i), 3'(i), 1'b0, 4'h0, 1'b0, 1'b0), 16'h0, 16'h0);
      chk("R10 reset bus A", bus_a_o, 16'h0000);
      chk("R2 reset bus B", bus_b_o, 16'h0000);
    end

    // Vector table: R6, R7, R8, R9, R3
    for (int i = 0; i < NV; i++) begin
      fs = VEC[i][53:50];
      r  = VEC[i][17:2];
      tag = (fs < 4'h8) ? "R6" : ((fs < 4'hC) ? "R7" : "R8");
      step(mk(3'd1, 3'd0, 3'd0, 1'b0, 4'h0, 1'b1, 1'b1), 16'h0, VEC[i][49:34]);
      step(mk(3'd2, 3'd0, 3'd0, 1'b0, 4'h0, 1'b1, 1'b1), 16'h0, VEC[i][33:18]);
      step(mk(3'd3, 3'd1, 3'd2, 1'b0, fs, 1'b0, 1'b1), 16'h0, 16'h0);
      chk({tag, " carry"}, {15'b0, flag_c}, {15'b0, VEC[i][1]});
      chk({tag, " overflow"}, {15'b0, flag_v}, {15'b0, VEC[i][0]});
      chk("R9 zero", {15'b0, flag_z}, {15'b0, (r == 16'h0)});
      chk("R9 sign", {15'b0, flag_n}, {15'b0, r[15]});
      step(mk(3'd0, 3'd3, 3'd0, 1'b0, 4'h0, 1'b0, 1'b0), 16'h0, 16'h0);
      chk({tag, " R3 result"}, bus_a_o, r);
    end

    // R4: write enable low ignores data and destination
    step(mk(3'd4, 3'd0, 3'd0, 1'b0, 4'h0, 1'b1, 1'b1), 16'h0, 16'h5A5A);
    step(mk(3'd4, 3'd4, 3'd0, 1'b0, 4'h0, 1'b1, 1'b0), 16'h0, 16'hFFFF);
    step(mk(3'd4, 3'd4, 3'd0, 1'b0, 4'h0, 1'b0, 1'b0), 16'h0, 16'h0);
    chk("R4 no write", bus_a_o, 16'h5A5A);

    // R2: constant on bus B, R3 sum of register and constant
    step(mk(3'd6, 3'd4, 3'd4, 1'b1, 4'h2, 1'b0, 1'b1), 16'h0003, 16'h0);
    chk("R2 constant on bus B", bus_b_o, 16'h0003);
    step(mk(3'd0, 3'd6, 3'd0, 1'b0, 4'h0, 1'b0, 1'b0), 16'h0, 16'h0);
    chk("R3 register plus constant", bus_a_o, 16'h5A5D);

    // R3: read-before-write on same register, R0 writable
    step(mk(3'd0, 3'd0, 3'd0, 1'b0, 4'h0, 1'b1, 1'b1), 16'h0, 16'h0101);
    step(mk(3'd0, 3'd0, 3'd0, 1'b0, 4'h2, 1'b0, 1'b1), 16'h0, 16'h0);
    chk("R3 old value before edge", bus_a_o, 16'h0101);
    step(mk(3'd0, 3'd0, 3'd0, 1'b0, 4'h0, 1'b0, 1'b0), 16'h0, 16'h0);
    chk("R3 doubled after edge", bus_a_o, 16'h0202);

    // R5 and R9: external data written, flags still follow function unit
    step(mk(3'd7, 3'd0, 3'd0, 1'b0, 4'h5, 1'b1, 1'b1), 16'h0, 16'hC3C3);
    chk("R9 zero with external data", {15'b0, flag_z}, 16'h0001);
    chk("R9 carry with external data", {15'b0, flag_c}, 16'h0001);
    step(mk(3'd0, 3'd7, 3'd0, 1'b0, 4'h0, 1'b0, 1'b0), 16'h0, 16'h0);
    chk("R5 external data stored", bus_a_o, 16'hC3C3);

    // R10: mid-run reset clears a written register
    step(mk(3'd5, 3'd0, 3'd0, 1'b0, 4'h0, 1'b1, 1'b1), 16'h0, 16'h1111);
    step(mk(3'd0, 3'd5, 3'd0, 1'b0, 4'h0, 1'b0, 1'b0), 16'h0, 16'h0);
    chk("R10 written before reset", bus_a_o, 16'h1111);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R10 cleared by reset", bus_a_o, 16'h0000);

    finish_run();
  end
endmodule